// File: doc/BRIEF.md
# Audio Master Clock Ratio Generator

This block produces the master clock for a serial audio port. The port clock runs at 512 or 384 times the sample rate, and the block divides it down to a chosen sub-rate of that clock. A three-bit divide code selects the ratio. Code 4 passes the full port rate through, and each lower code halves it. On the 512·fs base this gives 512x, 256x, 128x, 64x and 32x. On the 384·fs base it gives 384x, 192x, 96x, 48x and 24x. Sample rates from 8 kHz to 192 kHz are covered by choosing the port clock.

The output is built from registers, so the divider needs a clock edge for every half period of the fastest output. For that reason the block runs on `clk`, which is twice the port clock. Code 4 therefore yields `clk`/2, which equals the port clock, and code 0 yields `clk`/32. A new code, run setting or base selection is applied only when the current output period finishes. Every period starts low, so no shortened pulse is ever produced. Codes 5 to 7 are rejected: the error flag is raised and the output stays low. When run is clear, the output is held low and the reported base falls back to 512·fs.

Top module: `audio_mclk_gen`

## Requirements
- R1: After reset, `mclk`, `ratio_err` and `base_384` are all low.
- R2: With `run` high and a code f between 0 and 4, `mclk` has a period of 2^(5−f) `clk` cycles. It is high for exactly half of each period.
- R3: With `run` low, `mclk` is held low from the end of the current period, which is at most 32 `clk` cycles away.
- R4: A code of 5, 6 or 7 raises `ratio_err` one `clk` cycle later, and `mclk` stays low while such a code is active. A code of 4 or below clears `ratio_err` one `clk` cycle later.
- R5: Changes to the code, run or base selection take effect only at the end of an `mclk` period, and each new period starts low. Every high pulse is 1, 2, 4, 8 or 16 `clk` cycles long.
- R6: `base_384` reports the latched base selection (1 = 384·fs family, 0 = 512·fs family) while running. When `run` is low it reports 0, the 512·fs default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Divider clock, twice the port clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_sel | input | 1 | Base family select: 1 = 384·fs, 0 = 512·fs |
| mult | input | 3 | Divide code; 4 = full port rate, each step down halves it |
| run | input | 1 | Enables the master clock output |
| mclk | output | 1 | Master clock output |
| ratio_err | output | 1 | Unsupported divide code flag |
| base_384 | output | 1 | Active base family, 1 = 384·fs |

## Verification
`ratio_err` is due one `clk` cycle after `mult` changes, so the bench checks it at the next falling edge. `mclk` and `base_384` change only when an output period ends, which is up to 32 cycles after a stimulus. For these outputs the bench first waits 80 cycles. It then counts high samples and rising edges over a window of exactly eight expected periods, and that count does not depend on the phase. A pulse monitor runs during the whole test and checks the length of every high pulse, so a switch in the middle of a period cannot hide a runt pulse.

// File: rtl/audio_mclk_gen.sv
module audio_mclk_gen #(
  parameter int CODE_W   = 3,
  parameter int TOP_CODE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_sel,
  input  logic [CODE_W-1:0] mult,
  input  logic              run,
  output logic              mclk,
  output logic              ratio_err,
  output logic              base_384
);

  localparam int CW = TOP_CODE + 1;

  logic [CW-1:0]     cnt;
  logic [CW-1:0]     cnt_n;
  logic [CODE_W-1:0] code_a;
  logic [CODE_W-1:0] sel;
  logic              run_a;
  logic              valid_a;
  logic              term;
  int                last_i;

  assign valid_a = (code_a <= CODE_W'(TOP_CODE));
  assign sel     = valid_a ? CODE_W'(TOP_CODE) - code_a : '0;
  assign last_i  = valid_a ? ((1 << (int'(sel) + 1)) - 1) : 1;
  assign term    = (int'(cnt) == last_i);
  assign cnt_n   = cnt + CW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      code_a    <= CODE_W'(TOP_CODE);
      run_a     <= 1'b0;
      base_384  <= 1'b0;
      mclk      <= 1'b0;
      ratio_err <= 1'b0;
    end else begin
      ratio_err <= (mult > CODE_W'(TOP_CODE));
      if (term) begin
        cnt      <= '0;
        code_a   <= mult;
        run_a    <= run;
        base_384 <= run & base_sel;
        mclk     <= 1'b0;
      end else begin
        cnt  <= cnt_n;
        mclk <= run_a & valid_a & cnt_n[sel];
      end
    end
  end

  p_cfg_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |-> $stable(code_a));

  p_period_starts_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0) |-> !mclk);

  p_idle_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_a || !valid_a) |-> !mclk);

  p_base_default_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !run_a |-> !base_384);

  p_err_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (ratio_err == ($past(mult) > CODE_W'(TOP_CODE))));

  p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) <= last_i);

endmodule

// File: tb/audio_mclk_gen_tb_top.sv
module audio_mclk_gen_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       base_sel = 1'b0;
  logic [2:0] mult = 3'd4;
  logic       run = 1'b0;
  logic       mclk, ratio_err, base_384;

  int tests = 0;
  int fails = 0;
  int runt_bad = 0;
  int hi_len = 0;
  bit done = 0;

  audio_mclk_gen dut_i (
    .clk(clk), .rst_n(rst_n), .base_sel(base_sel), .mult(mult), .run(run),
    .mclk(mclk), .ratio_err(ratio_err), .base_384(base_384)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int exp_period(input int f);
    return 1 << (5 - f);
  endfunction

  function automatic bit exp_err(input int f);
    return f > 4;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R5 pulse monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (mclk) hi_len++;
      else if (hi_len > 0) begin
        if (!(hi_len == 1 || hi_len == 2 || hi_len == 4 || hi_len == 8 || hi_len == 16))
          runt_bad++;
        hi_len = 0;
      end
    end else hi_len = 0;
  end

  task automatic measure(input int f, input bit on, input string req);
    int p, hi, rises;
    bit prev;
    p = exp_period((f > 4) ? 4 : f);
    repeat (80) @(negedge clk);
    hi = 0; rises = 0; prev = mclk;
    repeat (8 * p) begin
      @(negedge clk);
      if (mclk) hi++;
      if (mclk && !prev) rises++;
      prev = mclk;
    end
    if (on && f <= 4) begin
      check({req, " high samples"}, hi, 4 * p);
      check({req, " rising edges"}, rises, 8);
    end else begin
      check({req, " held low"}, hi, 0);
    end
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 mclk reset", mclk, 0);
    check("R1 ratio_err reset", ratio_err, 0);
    check("R1 base_384 reset", base_384, 0);
    rst_n = 1'b1;

    // R2 directed sweep
    run = 1'b1;
    for (int f = 0; f <= 4; f++) begin
      mult = 3'(f);
      measure(f, 1'b1, "R2 sweep");
    end

    // R4 invalid codes, one-cycle latency
    for (int f = 5; f <= 7; f++) begin
      @(negedge clk); mult = 3'(f);
      @(negedge clk);
      check("R4 err latency", ratio_err, 1);
      measure(f, 1'b1, "R4 invalid code");
    end
    @(negedge clk); mult = 3'd2;
    @(negedge clk);
    check("R4 err clears", ratio_err, 0);

    // R6 base family
    base_sel = 1'b1;
    measure(2, 1'b1, "R6 run with 384 base");
    check("R6 base reported", base_384, 1);

    // R3 run low
    run = 1'b0;
    measure(2, 1'b0, "R3 run low");
    check("R6 base default 512", base_384, 0);

    // R5 change mid-period: switch from slowest to fastest after a rising edge
    run = 1'b1; mult = 3'd0; base_sel = 1'b0;
    repeat (80) @(negedge clk);
    begin
      bit prev;
      int hold;
      prev = mclk;
      @(negedge clk);
      while (!(mclk && !prev)) begin prev = mclk; @(negedge clk); end
      mult = 3'd4;
      hold = 0;
      repeat (15) begin @(negedge clk); if (mclk) hold++; end
      check("R5 current period completes", hold, 15);
    end
    measure(4, 1'b1, "R5 new code applied");

    // random mix
    for (int i = 0; i < 12; i++) begin
      int f;
      bit b, r;
      f = int'($urandom_range(0, 7));
      b = 1'($urandom_range(0, 1));
      r = ($urandom_range(0, 3) != 0);
      @(negedge clk);
      mult = 3'(f); base_sel = b; run = r;
      @(negedge clk);
      check("R4 random err", ratio_err, int'(exp_err(f)));
      measure(f, r, "R2 random");
      check("R6 random base", base_384, int'(r & b));
    end

    check("R5 no runt pulses", runt_bad, 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule